// File: doc/BRIEF.md
# AUX Read Retry Sequencer

This block runs a single read over an auxiliary display channel by talking to a lower-level channel engine. After a start pulse it captures the target (native register space or I2C-over-AUX), the address, the requested byte count and the middle-of-transaction flag. It then presents a request to the engine, waits for the engine's completion handshake, and decides whether to finish or to issue the request again.

Four independent retry counters cover channel timeouts, invalid replies, native deferrals and I2C deferrals. Each counter has its own limit and its own clearing rule. When the transfer ends, the block emits a one-cycle done pulse together with a 3-bit status, a success flag and the granted length. Retries of I2C-type requests wait a programmable number of cycles before the request is issued again. Native retries go out again at once.

Top module: `aux_rd_retry_seq`

## Requirements
- R1: A start pulse while idle latches the request. For a native read, req_action is 0, req_i2c is 0 and req_addr equals addr_in. For I2C-over-AUX, req_i2c is 1 and req_addr is addr_in[7:1] with the upper bits zero. req_action is 2 when mot is set and 1 when it is clear. req_len equals len_in. These fields stay constant until the transfer ends.
- R2: The channel result code 1 (timeout) triggers a retry. The third timeout in a row ends the transfer with status 2 (timeout).
- R3: The channel result code 2 (invalid reply) triggers a retry. The second invalid reply in a row ends the transfer with status 3 (protocol error).
- R4: A completion with result code 0 (good channel) clears both the timeout count and the invalid-reply count, whatever the reply code.
- R5: Reply code 2 (native defer) triggers a retry. The seventh native defer without an intervening clear ends the transfer with status 2.
- R6: Reply code 3 (I2C defer) clears the native defer count and triggers a retry. The seventh I2C defer in the transfer ends it with status 2.
- R7: Reply code 0 (ACK) ends the transfer. If ch_count exceeds the requested length, the status is 3 and rd_len is 0. Otherwise the status is 0, success is 1 and rd_len equals ch_count.
- R8: Reply code 1 (NACK) ends the transfer at once with status 1.
- R9: Channel result code 3, or any reply code of 4 or more on a good channel, ends the transfer with status 4 (unknown).
- R10: req_valid is a one-cycle pulse. A native retry pulses req_valid in the cycle after the completion is sampled. An I2C retry pulses it retry_delay cycles later than that. done rises in the cycle after the final completion is sampled.
- R11: done lasts exactly one cycle, and success is 1 exactly when the status is 0. After reset, busy, done, req_valid, status, success and rd_len are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read; honoured only while idle |
| is_i2c | input | 1 | 1 selects I2C-over-AUX, 0 selects a native read |
| mot | input | 1 | Middle-of-transaction flag for I2C reads |
| addr_in | input | ADDR_W | Native address, or 8-bit device address in bits 7:0 |
| len_in | input | LEN_W | Requested byte count |
| retry_delay | input | DLY_W | Cycles to wait before reissuing an I2C request |
| req_valid | output | 1 | One-cycle request strobe to the channel engine |
| req_i2c | output | 1 | Request type: 1 for I2C-over-AUX |
| req_action | output | 2 | 0 native read, 1 I2C read, 2 I2C read with MOT |
| req_addr | output | ADDR_W | Address presented to the engine |
| req_len | output | LEN_W | Length presented to the engine |
| ch_done | input | 1 | Engine completion strobe |
| ch_result | input | 2 | 0 good, 1 timeout, 2 invalid reply, 3 other |
| ch_count | input | LEN_W | Byte count returned by the engine |
| rep_code | input | 3 | 0 ACK, 1 NACK, 2 native defer, 3 I2C defer, others unknown |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 3 | 0 success, 1 NACK, 2 timeout, 3 protocol error, 4 unknown |
| success | output | 1 | Final outcome is success |
| rd_len | output | LEN_W | Granted length on success, 0 otherwise |

## Verification
The embedded assertions check the cycle-level invariants on every cycle:
- strobes lasting one cycle;
- success agreeing with the status;
- request fields holding still while busy;
- no retry counter sitting above its limit while a reply is awaited.

Only the bench's scenarios show that the limits trigger on the right attempt and that each counter clears on the right reply. Those scenarios also measure the retry spacing and the granted length. Mixed sequences of timeouts, invalid replies and both defer kinds prove the cross-clearing rules. A scenario with seven defers only ends the transfer when no clearing reply came between them.

// File: rtl/aux_rd_retry_seq.sv
module aux_rd_retry_seq #(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 5,
  parameter int DLY_W       = 8,
  parameter int TO_LIMIT    = 2,
  parameter int INV_LIMIT   = 1,
  parameter int DEFER_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_i2c,
  input  logic              mot,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [DLY_W-1:0]  retry_delay,
  output logic              req_valid,
  output logic              req_i2c,
  output logic [1:0]        req_action,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  input  logic              ch_done,
  input  logic [1:0]        ch_result,
  input  logic [LEN_W-1:0]  ch_count,
  input  logic [2:0]        rep_code,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic              success,
  output logic [LEN_W-1:0]  rd_len
);
  localparam int MAXL = (TO_LIMIT > DEFER_LIMIT) ?
                        ((TO_LIMIT > INV_LIMIT) ? TO_LIMIT : INV_LIMIT) :
                        ((DEFER_LIMIT > INV_LIMIT) ? DEFER_LIMIT : INV_LIMIT);
  localparam int CW = $clog2(MAXL + 2);
  localparam logic [CW-1:0] TO_L  = CW'(TO_LIMIT);
  localparam logic [CW-1:0] INV_L = CW'(INV_LIMIT);
  localparam logic [CW-1:0] DEF_L = CW'(DEFER_LIMIT);

  localparam logic [2:0] ST_OK = 3'd0, ST_NACK = 3'd1, ST_TO = 3'd2,
                         ST_PROT = 3'd3, ST_UNK = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DELAY} state_t;
  state_t state;

  logic [CW-1:0]    to_cnt, inv_cnt, nd_cnt, id_cnt;
  logic [DLY_W-1:0] dly_q, dcnt;
  logic             fin;
  logic [2:0]       fin_st;
  logic             got;

  assign busy      = (state != S_IDLE);
  assign req_valid = (state == S_ISSUE);
  assign got       = (state == S_WAIT) && ch_done;

  always_comb begin
    fin    = 1'b0;
    fin_st = ST_UNK;
    case (ch_result)
      2'd0:
        case (rep_code)
          3'd0: begin fin = 1'b1; fin_st = (ch_count > req_len) ? ST_PROT : ST_OK; end
          3'd1: begin fin = 1'b1; fin_st = ST_NACK; end
          3'd2: begin fin = (nd_cnt >= DEF_L); fin_st = ST_TO; end
          3'd3: begin fin = (id_cnt >= DEF_L); fin_st = ST_TO; end
          default: fin = 1'b1;
        endcase
      2'd1: begin fin = (to_cnt >= TO_L);   fin_st = ST_TO;   end
      2'd2: begin fin = (inv_cnt >= INV_L); fin_st = ST_PROT; end
      default: fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      req_i2c    <= 1'b0;
      req_action <= 2'd0;
      req_addr   <= '0;
      req_len    <= '0;
      dly_q      <= '0;
      dcnt       <= '0;
      to_cnt     <= '0;
      inv_cnt    <= '0;
      nd_cnt     <= '0;
      id_cnt     <= '0;
      done       <= 1'b0;
      status     <= ST_OK;
      success    <= 1'b0;
      rd_len     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (start) begin
            state      <= S_ISSUE;
            req_i2c    <= is_i2c;
            req_action <= is_i2c ? (mot ? 2'd2 : 2'd1) : 2'd0;
            req_addr   <= is_i2c ? ADDR_W'(addr_in[7:1]) : addr_in;
            req_len    <= len_in;
            dly_q      <= retry_delay;
            to_cnt     <= '0;
            inv_cnt    <= '0;
            nd_cnt     <= '0;
            id_cnt     <= '0;
          end
        S_ISSUE: state <= S_WAIT;
        S_WAIT:
          if (ch_done) begin
            case (ch_result)
              2'd0: begin
                to_cnt  <= '0;
                inv_cnt <= '0;
                if (rep_code == 3'd0) nd_cnt <= '0;
                if (rep_code == 3'd2) nd_cnt <= nd_cnt + CW'(1);
                if (rep_code == 3'd3) begin
                  nd_cnt <= '0;
                  id_cnt <= id_cnt + CW'(1);
                end
              end
              2'd1: to_cnt  <= to_cnt + CW'(1);
              2'd2: inv_cnt <= inv_cnt + CW'(1);
              default: ;
            endcase
            if (fin) begin
              state   <= S_IDLE;
              done    <= 1'b1;
              status  <= fin_st;
              success <= (fin_st == ST_OK);
              rd_len  <= (fin_st == ST_OK) ? ch_count : '0;
            end else if (req_i2c && dly_q != '0) begin
              state <= S_DELAY;
              dcnt  <= dly_q;
            end else begin
              state <= S_ISSUE;
            end
          end
        S_DELAY: begin
          dcnt <= dcnt - DLY_W'(1);
          if (dcnt == DLY_W'(1)) state <= S_ISSUE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  success_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (success == (status == ST_OK)));

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(req_addr) && $stable(req_action) && $stable(req_len)));

  // R2
  to_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> (to_cnt <= TO_L));

  // R3
  inv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> (inv_cnt <= INV_L));

  // R5
  nd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> (nd_cnt <= DEF_L));

  // R6
  id_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> (id_cnt <= DEF_L));
endmodule

// File: tb/aux_rd_retry_seq_bench.sv
module aux_rd_retry_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_i2c = 1'b0, mot = 1'b0;
  logic [19:0] addr_in = '0;
  logic [4:0]  len_in = '0;
  logic [7:0]  retry_delay = '0;
  logic        req_valid, req_i2c;
  logic [1:0]  req_action;
  logic [19:0] req_addr;
  logic [4:0]  req_len;
  logic        ch_done = 1'b0;
  logic [1:0]  ch_result = '0;
  logic [4:0]  ch_count = '0;
  logic [2:0]  rep_code = '0;
  logic        busy, done, success;
  logic [2:0]  status;
  logic [4:0]  rd_len;

  int checks = 0, errors = 0;
  int q_res[$], q_code[$], q_cnt[$];

  always #(PERIOD/2) clk = ~clk;

  aux_rd_retry_seq u_aux_rd_retry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_i2c(is_i2c), .mot(mot),
    .addr_in(addr_in), .len_in(len_in), .retry_delay(retry_delay),
    .req_valid(req_valid), .req_i2c(req_i2c), .req_action(req_action),
    .req_addr(req_addr), .req_len(req_len), .ch_done(ch_done),
    .ch_result(ch_result), .ch_count(ch_count), .rep_code(rep_code),
    .busy(busy), .done(done), .status(status), .success(success), .rd_len(rd_len)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int r, input int c, input int n);
    q_res.push_back(r); q_code.push_back(c); q_cnt.push_back(n);
  endtask

  task automatic run_case(input string req, input bit i2c, input bit m,
                          input logic [19:0] a, input int l, input int d);
    int est, en, elen, to, inv, nd, id, reqs, since, cyc, eact;
    logic [19:0] eaddr;
    bit fin, pend;
    est = -1; en = 0; elen = 0; to = 0; inv = 0; nd = 0; id = 0;
    reqs = 0; since = -1; cyc = 0; fin = 0; pend = 0;
    for (int i = 0; i < q_res.size(); i++) begin
      en++;
      if (q_res[i] == 1) begin to++; if (to > 2) est = 2; end
      else if (q_res[i] == 2) begin inv++; if (inv > 1) est = 3; end
      else if (q_res[i] == 3) est = 4;
      else begin
        to = 0; inv = 0;
        case (q_code[i])
          0: begin nd = 0; if (q_cnt[i] > l) est = 3; else begin est = 0; elen = q_cnt[i]; end end
          1: est = 1;
          2: begin nd++; if (nd > 6) est = 2; end
          3: begin nd = 0; id++; if (id > 6) est = 2; end
          default: est = 4;
        endcase
      end
      if (est >= 0) break;
    end
    eact  = i2c ? (m ? 2 : 1) : 0;
    eaddr = i2c ? {13'd0, a[7:1]} : a;

    @(negedge clk);
    is_i2c = i2c; mot = m; addr_in = a; len_in = 5'(l); retry_delay = 8'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 3000) begin
      ch_done = 1'b0;
      if (since >= 0) since++;
      if (done) begin
        fin = 1;
        chk(since == 1, "R10", {req, " done latency"}, since, 1);
        chk(int'(status) == est, req, "status", status, est);
        chk(success == (est == 0), "R11", {req, " success"}, success, est == 0);
        chk(int'(rd_len) == (est == 0 ? elen : 0), "R7", {req, " rd_len"}, rd_len, est == 0 ? elen : 0);
        chk(reqs == en, req, "request count", reqs, en);
      end else if (req_valid) begin
        reqs++;
        chk(req_i2c == i2c && int'(req_action) == eact, "R1", {req, " type/action"}, req_action, eact);
        chk(req_addr == eaddr, "R1", {req, " address"}, req_addr, eaddr);
        chk(int'(req_len) == l, "R1", {req, " length"}, req_len, l);
        if (since >= 0)
          chk(since == ((i2c && d > 0) ? d + 1 : 1), "R10", {req, " retry spacing"}, since,
              (i2c && d > 0) ? d + 1 : 1);
        since = -1;
        pend = 1;
      end else if (pend) begin
        pend = 0;
        since = 0;
        ch_done = 1'b1;
        ch_result = 2'(q_res.pop_front());
        rep_code  = 3'(q_code.pop_front());
        ch_count  = 5'(q_cnt.pop_front());
      end
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) chk(0, req, "no done", 0, 1);
    @(negedge clk);
    chk(!done && !busy, "R11", {req, " done one cycle"}, done, 0);
    q_res.delete(); q_code.delete(); q_cnt.delete();
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid && status == 0 && !success && rd_len == 0,
        "R11", "reset state", {busy, done, req_valid, success}, 0);

    // R7 plain success, native
    push(0, 0, 4);
    run_case("R7", 0, 0, 20'h12345, 4, 5);
    // R7 count over length
    push(0, 0, 5);
    run_case("R7", 0, 0, 20'h00200, 4, 0);
    // R2 and R10: I2C with MOT, two timeouts then success, delay 3
    push(1, 0, 0); push(1, 0, 0); push(0, 0, 2);
    run_case("R2", 1, 1, 20'h000A1, 2, 3);
    // R2 third timeout fails
    push(1, 0, 0); push(1, 0, 0); push(1, 0, 0);
    run_case("R2", 0, 0, 20'h00010, 1, 0);
    // R3 second invalid reply fails
    push(2, 0, 0); push(2, 0, 0);
    run_case("R3", 0, 0, 20'h00011, 1, 0);
    // R4 good channel clears timeout and invalid counts
    push(1, 0, 0); push(1, 0, 0); push(0, 2, 0); push(1, 0, 0); push(1, 0, 0);
    push(2, 0, 0); push(0, 2, 0); push(2, 0, 0); push(0, 0, 1);
    run_case("R4", 0, 0, 20'h00300, 3, 0);
    // R5 seventh native defer fails
    for (int i = 0; i < 7; i++) push(0, 2, 0);
    run_case("R5", 0, 0, 20'h00400, 2, 0);
    // R6 I2C defer clears native defer count; I2C read without MOT
    for (int i = 0; i < 6; i++) push(0, 2, 0);
    push(0, 3, 0);
    for (int i = 0; i < 6; i++) push(0, 2, 0);
    push(0, 0, 0);
    run_case("R6", 1, 0, 20'hFFF50, 3, 0);
    // R6 seventh I2C defer fails, delay 1
    for (int i = 0; i < 7; i++) push(0, 3, 0);
    run_case("R6", 1, 1, 20'h00036, 1, 1);
    // R8 NACK
    push(0, 1, 0);
    run_case("R8", 0, 0, 20'h00500, 1, 0);
    // R9 unknown channel result, unknown reply code
    push(3, 0, 0);
    run_case("R9", 0, 0, 20'h00600, 1, 0);
    push(1, 0, 0); push(0, 5, 0);
    run_case("R9", 1, 0, 20'h00070, 1, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule